// File: doc/BRIEF.md
# Complex Sample Output Formatter

This block takes complex sample pairs (an I word and a Q word, qualified by a valid strobe) and presents them to the outside world either as registered parallel words or as serial bit streams. A set of static control inputs chooses between the two presentations, and in serial mode it also sets the bit rate, the line arrangement, the bit order and the bit clock phase. Every word can be converted from two's complement to offset binary on the way out.

In serial mode the block makes its own bit clock by dividing the system clock by 1, 2, 4 or 8. A pair is sent either as I and Q side by side on two lines, or as I followed by Q on a single line. A data-ready flag, whose active level is programmable, marks the first bit period of each transfer. One pair that arrives while a transfer is running waits in a single-entry holding slot and goes out straight after. A pair that arrives while that slot is already taken is dropped, and a sticky overflow flag is raised.

The control inputs are expected to stay constant while a transfer is in progress.

Top module: `iq_out_fmt`

## Requirements
- R1: With `cfg_serial`=0, a pair sampled with `in_valid` high at a clock edge appears on `par_i`/`par_q` right after that edge, and the ready flag is active for that one cycle only. The words hold until the next pair.
- R2: With `cfg_offset_bin`=1, every output word has its most significant bit inverted and all other bits unchanged. With 0, words pass through as two's complement. This applies in both the parallel and the serial mode.
- R3: `data_rdy` is high when active if `cfg_rdy_low`=0, and low when active if `cfg_rdy_low`=1. When inactive it sits at the level of `cfg_rdy_low`.
- R4: In serial mode one bit period lasts 2^`cfg_rate` system clocks: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8. A transfer starts in the cycle after the edge that accepts the pair.
- R5: With `cfg_iq_seq`=0, a transfer lasts DATA_W bit periods, with I on `ser_a` and Q on `ser_b` at the same time.
- R6: With `cfg_iq_seq`=1, a transfer lasts 2*DATA_W bit periods on `ser_a`: first all of I, then all of Q. `ser_b` stays 0.
- R7: With `cfg_msb_first`=1, each word is sent starting from bit DATA_W-1. With 0, it is sent starting from bit 0.
- R8: In serial mode the ready flag is active for exactly the first bit period of each transfer.
- R9: When the bit period is 2 or more, `ser_clk` equals `cfg_clk_fall` for the first half of each bit period and its inverse for the second half. This puts a high-to-low edge at mid-bit when `cfg_clk_fall`=1 and a low-to-high edge when it is 0. When the bit period is 1, `ser_clk` follows the system clock during a transfer (inverted when `cfg_clk_fall`=0). When idle it rests at the inverse of `cfg_clk_fall`.
- R10: A pair accepted while a transfer runs and the holding slot is empty is sent immediately after the current transfer, with no idle cycle in between.
- R11: A pair accepted while a transfer runs and the holding slot is full is discarded, and `overflow` goes high and stays high until reset.
- R12: During and right after reset, `par_i`, `par_q`, `ser_a`, `ser_b` and `overflow` are 0, `data_rdy` is inactive and `ser_clk` is at its idle level.
- R13: `ser_a` and `ser_b` are 0 whenever no transfer is running, including in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_serial | input | 1 | 1 selects serial output, 0 selects parallel output |
| cfg_rate | input | 2 | Serial bit period select: 2^code system clocks |
| cfg_iq_seq | input | 1 | 1 sends I then Q on one line, 0 sends I and Q on two lines |
| cfg_msb_first | input | 1 | 1 sends the MSB first, 0 sends the LSB first |
| cfg_offset_bin | input | 1 | 1 outputs offset binary, 0 outputs two's complement |
| cfg_rdy_low | input | 1 | 1 makes data_rdy active low |
| cfg_clk_fall | input | 1 | 1 puts a falling bit-clock edge at mid-bit, 0 a rising edge |
| in_valid | input | 1 | Input pair strobe |
| in_i | input | DATA_W | In-phase sample, two's complement |
| in_q | input | DATA_W | Quadrature sample, two's complement |
| par_i | output | DATA_W | Parallel I word |
| par_q | output | DATA_W | Parallel Q word |
| ser_a | output | 1 | Serial line carrying I, or I then Q |
| ser_b | output | 1 | Serial line carrying Q in two-line mode |
| ser_clk | output | 1 | Serial bit clock |
| data_rdy | output | 1 | Data-ready flag with programmable polarity |
| overflow | output | 1 | Sticky flag for a pair lost while the slot was full |

## Verification
The hardest condition to reach from the ports is the overflow case. It needs three pairs in flight at once: one being shifted, one waiting in the holding slot, and a third arriving before the first transfer ends. The stimulus starts a transfer and then, on the following two cycles, injects a second and a third pair. It then follows every bit period of both the current and the buffered transfer, across random rates, orders, line modes and polarities. This shows that the buffered pair leaves with no gap, that the third pair never appears, and that the flag sticks.

// File: rtl/iqf_pkg.sv
`timescale 1ns/1ps
package iqf_pkg;
  localparam int MAX_PERIOD = 8;
  localparam int PH_W = $clog2(MAX_PERIOD);

  // number of system clocks per serial bit for a rate code
  function automatic int bit_period(input logic [1:0] code);
    return 1 << code;
  endfunction
endpackage

// File: rtl/iqf_fmt.sv
`timescale 1ns/1ps
module iqf_fmt #(
  parameter int W = 12
) (
  input  logic [W-1:0] din,
  input  logic         offset_bin,
  output logic [W-1:0] dout
);
  // offset binary = two's complement with the sign bit flipped
  always_comb begin
    dout = din;
    if (offset_bin) dout[W-1] = ~din[W-1];
  end
endmodule

// File: rtl/iqf_bitclk.sv
`timescale 1ns/1ps
module iqf_bitclk
  import iqf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  input  logic       clk_fall,
  output logic       bit_end,
  output logic       ser_clk
);
  logic [PH_W-1:0] ph;
  int              per;

  always_comb per = bit_period(rate);

  assign bit_end = run && (int'(ph) == per - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)              ph <= '0;
    else if (!run || bit_end) ph <= '0;
    else                     ph <= ph + 1'b1;
  end

  always_comb begin
    if (!run)          ser_clk = ~clk_fall;
    else if (per == 1) ser_clk = clk_fall ? clk : ~clk;
    else               ser_clk = (int'(ph) < per / 2) ? clk_fall : ~clk_fall;
  end

  assert_phase_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ph == '0);
  assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> int'(ph) < per);
endmodule

// File: rtl/iqf_par_reg.sv
`timescale 1ns/1ps
module iqf_par_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  output logic [W-1:0] par_i,
  output logic [W-1:0] par_q,
  output logic         rdy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_i <= '0;
      par_q <= '0;
      rdy   <= 1'b0;
    end else begin
      rdy <= take;
      if (take) begin
        par_i <= in_i;
        par_q <= in_q;
      end
    end
  end

  assert_par_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(par_i) && $stable(par_q) && !rdy);
endmodule

// File: rtl/iqf_serializer.sv
`timescale 1ns/1ps
module iqf_serializer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  input  logic         iq_seq,
  input  logic         msb_first,
  input  logic         bit_end,
  output logic         busy,
  output logic         ser_a,
  output logic         ser_b,
  output logic         rdy,
  output logic         ovf
);
  localparam int CW = $clog2(2 * W) + 1;
  localparam int IW = $clog2(W);

  logic [W-1:0]  cur_i, cur_q, hold_i, hold_q;
  logic          hold_full;
  logic [CW-1:0] bcnt, last_idx, q_idx;
  logic          last_bit;

  function automatic logic pick(input logic [W-1:0] word, input logic [CW-1:0] idx,
                                input logic msb);
    logic [IW-1:0] k;
    k = msb ? (IW'(W - 1) - idx[IW-1:0]) : idx[IW-1:0];
    return word[k];
  endfunction

  assign last_idx = iq_seq ? CW'(2 * W - 1) : CW'(W - 1);
  assign last_bit = bit_end && (bcnt == last_idx);
  assign q_idx    = bcnt - CW'(W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bcnt      <= '0;
      cur_i     <= '0;
      cur_q     <= '0;
      hold_i    <= '0;
      hold_q    <= '0;
      hold_full <= 1'b0;
      ovf       <= 1'b0;
    end else if (!busy) begin
      if (take) begin
        cur_i <= in_i;
        cur_q <= in_q;
        busy  <= 1'b1;
        bcnt  <= '0;
      end
    end else if (last_bit) begin
      bcnt <= '0;
      if (hold_full) begin
        cur_i     <= hold_i;
        cur_q     <= hold_q;
        hold_full <= take;
        if (take) begin
          hold_i <= in_i;
          hold_q <= in_q;
        end
      end else if (take) begin
        cur_i <= in_i;
        cur_q <= in_q;
      end else begin
        busy <= 1'b0;
      end
    end else begin
      if (bit_end) bcnt <= bcnt + 1'b1;
      if (take) begin
        if (hold_full) ovf <= 1'b1;
        else begin
          hold_i    <= in_i;
          hold_q    <= in_q;
          hold_full <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    ser_a = 1'b0;
    ser_b = 1'b0;
    if (busy) begin
      if (iq_seq) begin
        ser_a = (bcnt < CW'(W)) ? pick(cur_i, bcnt, msb_first) : pick(cur_q, q_idx, msb_first);
      end else begin
        ser_a = pick(cur_i, bcnt, msb_first);
        ser_b = pick(cur_q, bcnt, msb_first);
      end
    end
  end

  assign rdy = busy && (bcnt == '0);

  assert_hold_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |-> busy);
  assert_no_overflow_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_lines_hold_in_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bit_end |=> $stable(ser_a) && $stable(ser_b));
  assert_rdy_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rdy);
  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt <= last_idx);
endmodule

// File: rtl/iq_out_fmt.sv
`timescale 1ns/1ps
module iq_out_fmt #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_serial,
  input  logic [1:0]        cfg_rate,
  input  logic              cfg_iq_seq,
  input  logic              cfg_msb_first,
  input  logic              cfg_offset_bin,
  input  logic              cfg_rdy_low,
  input  logic              cfg_clk_fall,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] par_i,
  output logic [DATA_W-1:0] par_q,
  output logic              ser_a,
  output logic              ser_b,
  output logic              ser_clk,
  output logic              data_rdy,
  output logic              overflow
);
  localparam int LANES = 2;

  logic [DATA_W-1:0] raw  [LANES];
  logic [DATA_W-1:0] fmtd [LANES];
  logic take_par, take_ser, busy, bit_end, rdy_par, rdy_ser, rdy_active;

  assign raw[0] = in_i;
  assign raw[1] = in_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    iqf_fmt #(.W(DATA_W)) u_fmt (
      .din(raw[g]), .offset_bin(cfg_offset_bin), .dout(fmtd[g])
    );
  end

  assign take_par = in_valid && !cfg_serial;
  assign take_ser = in_valid && cfg_serial;

  iqf_par_reg #(.W(DATA_W)) u_par (
    .clk(clk), .rst_n(rst_n), .take(take_par),
    .in_i(fmtd[0]), .in_q(fmtd[1]),
    .par_i(par_i), .par_q(par_q), .rdy(rdy_par)
  );

  iqf_bitclk u_bclk (
    .clk(clk), .rst_n(rst_n), .run(busy), .rate(cfg_rate),
    .clk_fall(cfg_clk_fall), .bit_end(bit_end), .ser_clk(ser_clk)
  );

  iqf_serializer #(.W(DATA_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .take(take_ser),
    .in_i(fmtd[0]), .in_q(fmtd[1]),
    .iq_seq(cfg_iq_seq), .msb_first(cfg_msb_first), .bit_end(bit_end),
    .busy(busy), .ser_a(ser_a), .ser_b(ser_b), .rdy(rdy_ser), .ovf(overflow)
  );

  assign rdy_active = cfg_serial ? rdy_ser : rdy_par;
  assign data_rdy   = rdy_active ^ cfg_rdy_low;

  assert_idle_lines_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_a && !ser_b);
  assert_single_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdy_par && rdy_ser));
endmodule

// File: tb/test_iq_out_fmt.sv
`timescale 1ns/1ps
module test_iq_out_fmt;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_serial = 0, cfg_iq_seq = 0, cfg_msb_first = 0;
  logic cfg_offset_bin = 0, cfg_rdy_low = 0, cfg_clk_fall = 0;
  logic [1:0] cfg_rate = 0;
  logic in_valid = 0;
  logic [W-1:0] in_i = 0, in_q = 0;
  logic [W-1:0] par_i, par_q;
  logic ser_a, ser_b, ser_clk, data_rdy, overflow;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  iq_out_fmt #(.DATA_W(W)) i_iq_out_fmt (
    .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial), .cfg_rate(cfg_rate),
    .cfg_iq_seq(cfg_iq_seq), .cfg_msb_first(cfg_msb_first),
    .cfg_offset_bin(cfg_offset_bin), .cfg_rdy_low(cfg_rdy_low),
    .cfg_clk_fall(cfg_clk_fall), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .par_i(par_i), .par_q(par_q), .ser_a(ser_a), .ser_b(ser_b),
    .ser_clk(ser_clk), .data_rdy(data_rdy), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int ef(input int x);
    return cfg_offset_bin ? (x ^ (1 << (W - 1))) : x;
  endfunction

  function automatic int bb(input int w, input int idx);
    return cfg_msb_first ? ((w >> (W - 1 - idx)) & 1) : ((w >> idx) & 1);
  endfunction

  function automatic int pick_val();
    case ($urandom % 8)
      0: return 0;
      1: return 1 << (W - 1);
      2: return (1 << (W - 1)) - 1;
      3: return (1 << W) - 1;
      default: return int'($urandom % (1 << W));
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    // R12 reset state
    check(par_i == 0 && par_q == 0, "R12 par words", int'(par_i), 0);
    check(ser_a == 0 && ser_b == 0 && overflow == 0, "R12 lines/overflow",
          int'({ser_a, ser_b, overflow}), 0);
    check(data_rdy == cfg_rdy_low, "R12 R3 rdy inactive", int'(data_rdy), int'(cfg_rdy_low));
    check(ser_clk == !cfg_clk_fall, "R12 R9 idle clock", int'(ser_clk), int'(!cfg_clk_fall));
    #1;
  endtask

  // serial scenario with n pairs: pair 1 arrives while busy, pair 2 overflows
  task automatic ser_run(input int n);
    int pi[3], pq[3];
    int per, nb, tlen, xfers;
    for (int k = 0; k < 3; k++) begin pi[k] = pick_val(); pq[k] = pick_val(); end
    cfg_serial = 1;
    do_reset();
    per = 1 << cfg_rate;
    nb = cfg_iq_seq ? 2 * W : W;
    tlen = nb * per;
    xfers = (n >= 2) ? 2 : 1;
    in_i = W'(pi[0]); in_q = W'(pq[0]); in_valid = 1;
    for (int s = 0; s < xfers * tlen; s++) begin
      int t, r, b, p, ei, eq, ea, eb, ec, er;
      @(posedge clk); #1;
      t = s / tlen; r = s % tlen; b = r / per; p = r % per;
      ei = ef(pi[t]); eq = ef(pq[t]);
      ea = cfg_iq_seq ? ((b < W) ? bb(ei, b) : bb(eq, b - W)) : bb(ei, b);
      eb = cfg_iq_seq ? 0 : bb(eq, b);
      ec = (per == 1) ? int'(cfg_clk_fall) : ((p < per / 2) ? int'(cfg_clk_fall) : int'(!cfg_clk_fall));
      er = int'(b == 0) ^ int'(cfg_rdy_low);
      check(int'(ser_a) == ea, "R5 R6 R7 R2 R10 ser_a bit", int'(ser_a), ea);
      check(int'(ser_b) == eb, "R5 R6 ser_b bit", int'(ser_b), eb);
      check(int'(ser_clk) == ec, "R9 R4 bit clock", int'(ser_clk), ec);
      check(int'(data_rdy) == er, "R8 R3 ready", int'(data_rdy), er);
      #1;
      if (s == 0 && n >= 2) begin
        in_i = W'(pi[1]); in_q = W'(pq[1]); in_valid = 1;
      end else if (s == 1 && n == 3) begin
        in_i = W'(pi[2]); in_q = W'(pq[2]); in_valid = 1;
      end else in_valid = 0;
    end
    @(posedge clk); #1;
    check(ser_a == 0 && ser_b == 0, "R13 idle lines", int'({ser_a, ser_b}), 0);
    check(ser_clk == !cfg_clk_fall, "R9 idle clock", int'(ser_clk), int'(!cfg_clk_fall));
    check(data_rdy == cfg_rdy_low, "R3 R8 idle ready", int'(data_rdy), int'(cfg_rdy_low));
    check(int'(overflow) == int'(n == 3), "R11 overflow", int'(overflow), int'(n == 3));
    #1;
  endtask

  task automatic par_run(input int count);
    cfg_serial = 0;
    do_reset();
    for (int k = 0; k < count; k++) begin
      int vi, vq, gap;
      vi = pick_val(); vq = pick_val(); gap = int'($urandom % 3);
      in_i = W'(vi); in_q = W'(vq); in_valid = 1;
      @(posedge clk); #1;
      check(int'(par_i) == ef(vi), "R1 R2 par_i", int'(par_i), ef(vi));
      check(int'(par_q) == ef(vq), "R1 R2 par_q", int'(par_q), ef(vq));
      check(data_rdy == !cfg_rdy_low, "R1 R3 ready active", int'(data_rdy), int'(!cfg_rdy_low));
      check(ser_a == 0 && ser_b == 0, "R13 lines in parallel", int'({ser_a, ser_b}), 0);
      #1;
      in_valid = 0;
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); #1;
        check(data_rdy == cfg_rdy_low, "R1 R3 ready single cycle", int'(data_rdy), int'(cfg_rdy_low));
        check(int'(par_i) == ef(vi) && int'(par_q) == ef(vq), "R1 words hold",
              int'(par_i), ef(vi));
        #1;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    // directed corners
    cfg_offset_bin = 1; cfg_rdy_low = 1; cfg_clk_fall = 1;
    par_run(12);
    cfg_offset_bin = 0; cfg_rdy_low = 0; cfg_clk_fall = 0;
    par_run(8);
    for (int rc = 0; rc < 4; rc++) begin
      cfg_rate = 2'(rc);
      cfg_iq_seq = rc[0]; cfg_msb_first = rc[1]; cfg_clk_fall = ~rc[0];
      cfg_offset_bin = rc[1]; cfg_rdy_low = rc[0];
      ser_run(1);
      ser_run(3);
    end
    cfg_rate = 0; cfg_iq_seq = 1; ser_run(2);
    // random mix
    for (int k = 0; k < 24; k++) begin
      cfg_rate = 2'($urandom % 4);
      cfg_iq_seq = 1'($urandom % 2); cfg_msb_first = 1'($urandom % 2);
      cfg_offset_bin = 1'($urandom % 2); cfg_rdy_low = 1'($urandom % 2);
      cfg_clk_fall = 1'($urandom % 2);
      ser_run(1 + int'($urandom % 3));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule